// File: doc/BRIEF.md
# Three-Point Peak Finder with Rate Halving and Shift Scaling

This block sits behind a FIR convolver. It looks for local maxima in the filtered sample stream and halves the sample rate. It then scales each kept result into a 10-bit word that can address an energy lookup table, together with a flag that reports the scaled value was too large for 10 bits. All logic runs on one fast clock. A single-cycle `in_valid` strobe marks each new convolver result, so samples may arrive on consecutive cycles or with idle cycles between them.

Each arriving sample is the "next" neighbour of a held candidate, and the candidate's "previous" neighbour is held one step further back. When peak detection is enabled, a candidate that is not a local maximum is replaced by zero. When it is disabled, the candidate passes through unchanged. A two-phase selector then keeps every second peak-stage result. The kept result is shifted right by 0 to 3 places. Its low 10 bits form the output word, and the bits shifted above bit 9 are ORed into the overflow flag.

Top module: `peak_decim_scale`

## Requirements
- R1: Only bits [18:3] of the 19-bit input take part in comparison and output, so bits [2:0] have no effect on any output.
- R2: With `peak_en`=1, a candidate is reported unchanged when it is strictly greater than the sample before it and greater than or equal to the sample after it; otherwise it is reported as zero.
- R3: A flat top made of two equal maxima yields exactly one nonzero result, taken at the first of the two equal samples.
- R4: With `peak_en`=0, every candidate is reported with its 16-bit value unchanged.
- R5: After reset, the first two valid samples produce no peak-stage result, because no candidate has a full neighbourhood yet. Samples that arrived before a reset are never used after it.
- R6: Peak-stage results are numbered 0, 1, 2, … from reset. The result is kept when its index parity equals `dec_phase`, so `out_valid` is never high on two consecutive cycles.
- R7: A kept result appears on the outputs with `out_valid` high after the third rising clock edge that follows the input sample completing its neighbourhood (the next sample). This latency is the same for both phases.
- R8: The kept 16-bit value is shifted right, with zero fill, by `div_sel` places (0 = /1, 1 = /2, 2 = /4, 3 = /8), and `out_peak` is bits [9:0] of the shifted value.
- R9: `out_ovf` is the OR of bits [15:10] of the shifted value.
- R10: Reset sets `out_valid`, `out_peak` and `out_ovf` to 0. When `out_valid` is low, `out_peak` and `out_ovf` hold the last reported values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: `in_data` holds a new convolver result |
| in_data | input | 19 | Unsigned convolver result |
| peak_en | input | 1 | 1 = three-point peak test active, 0 = pass-through |
| dec_phase | input | 1 | Parity of peak-stage results that are kept |
| div_sel | input | 2 | Right-shift amount 0..3 |
| out_valid | output | 1 | One-cycle strobe for a new scaled result |
| out_peak | output | 10 | Scaled result |
| out_ovf | output | 1 | Scaled value exceeded 10 bits |

## Verification
A fixed sequence of samples is run with several settings. It contains rising and falling slopes, a flat top, an isolated spike, idle gaps and garbage in the three dropped low bits. Running it with the peak test on and then off separates the comparison from the pass-through path. Running it with both phase values shows which results the decimator keeps and that their timing does not change. Large values at each shift setting, including values just below and just above 1024, separate correct truncation from a misplaced overflow boundary. A burst of back-to-back samples and a reset in the middle of a stream check that no candidate is built from history that arrived before the reset.

// File: rtl/pds_pkg.sv
package pds_pkg;
  // Candidate-window fill level after reset
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_FULL = 2'd2
  } fill_e;
endpackage

// File: rtl/pds_peak3.sv
module pds_peak3
  import pds_pkg::*;
#(
  parameter int IN_W  = 19,
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic             peak_en,
  output logic             pk_vld,
  output logic [CMP_W-1:0] pk_val
);
  localparam int LSB = IN_W - CMP_W;

  fill_e            fill_q, fill_d;
  logic [CMP_W-1:0] cand_q, prev_q, cur;
  logic [CMP_W-1:0] res;
  logic             is_peak;
  logic             emit;
  logic             unused_lsb;

  assign cur        = in_data[IN_W-1:LSB];
  assign unused_lsb = ^in_data[LSB-1:0];

  always_comb begin
    is_peak = (cand_q > prev_q) && (cand_q >= cur);
    if (peak_en) res = is_peak ? cand_q : '0;
    else         res = cand_q;
    emit   = in_valid && (fill_q == FILL_FULL);
    fill_d = fill_q;
    if (in_valid) begin
      unique case (fill_q)
        FILL_NONE: fill_d = FILL_ONE;
        default:   fill_d = FILL_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= FILL_NONE;
      cand_q <= '0;
      prev_q <= '0;
      pk_vld <= 1'b0;
      pk_val <= '0;
    end else begin
      pk_vld <= emit;
      if (emit) pk_val <= res;
      if (in_valid) begin
        prev_q <= cand_q;
        cand_q <= cur;
        fill_q <= fill_d;
      end
    end
  end

  // R5: no result until the window holds two earlier samples
  p_warmup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_q != FILL_FULL) |=> !pk_vld);

  // R2: a candidate not above its predecessor is reported as zero
  p_nonpeak_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && peak_en && fill_q == FILL_FULL && !(cand_q > prev_q)) |=> (pk_val == '0));

  // R4: pass-through reports the held candidate
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !peak_en && fill_q == FILL_FULL) |=> (pk_val == $past(cand_q)));
endmodule

// File: rtl/pds_decim2.sv
module pds_decim2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pk_vld,
  input  logic [W-1:0] pk_val,
  input  logic         dec_phase,
  output logic         dec_vld,
  output logic [W-1:0] dec_val
);
  logic par_q, par_d;
  logic keep;

  always_comb begin
    keep  = pk_vld && (par_q == dec_phase);
    par_d = pk_vld ? ~par_q : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q   <= 1'b0;
      dec_vld <= 1'b0;
      dec_val <= '0;
    end else begin
      par_q   <= par_d;
      dec_vld <= keep;
      if (keep) dec_val <= pk_val;
    end
  end

  // R6: kept results alternate with dropped ones
  p_skip_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_vld && dec_vld) |-> !keep);
endmodule

// File: rtl/pds_scale.sv
module pds_scale #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 10,
  parameter int SH_W  = 2
) (
  input  logic [IN_W-1:0]  val,
  input  logic [SH_W-1:0]  div_sel,
  output logic [OUT_W-1:0] scaled,
  output logic             ovf
);
  logic [IN_W-1:0] shifted;

  always_comb begin
    shifted = val >> div_sel;
    scaled  = shifted[OUT_W-1:0];
    ovf     = |shifted[IN_W-1:OUT_W];
  end
endmodule

// File: rtl/peak_decim_scale.sv
module peak_decim_scale #(
  parameter int IN_W  = 19,
  parameter int CMP_W = 16,
  parameter int OUT_W = 10,
  parameter int SH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic             peak_en,
  input  logic             dec_phase,
  input  logic [SH_W-1:0]  div_sel,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_peak,
  output logic             out_ovf
);
  logic             pk_vld, dec_vld;
  logic [CMP_W-1:0] pk_val, dec_val;
  logic [OUT_W-1:0] sc_val;
  logic             sc_ovf;

  pds_peak3 #(.IN_W(IN_W), .CMP_W(CMP_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .peak_en(peak_en), .pk_vld(pk_vld), .pk_val(pk_val)
  );

  pds_decim2 #(.W(CMP_W)) u_decim (
    .clk(clk), .rst_n(rst_n), .pk_vld(pk_vld), .pk_val(pk_val),
    .dec_phase(dec_phase), .dec_vld(dec_vld), .dec_val(dec_val)
  );

  pds_scale #(.IN_W(CMP_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
    .val(dec_val), .div_sel(div_sel), .scaled(sc_val), .ovf(sc_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_peak  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= dec_vld;
      if (dec_vld) begin
        out_peak <= sc_val;
        out_ovf  <= sc_ovf;
      end
    end
  end

  // R6: output strobe never on two adjacent cycles
  p_decim_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R10: outputs hold while no new result is kept
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |=> ($stable(out_peak) && $stable(out_ovf)));
endmodule

// File: tb/tb_peak_decim_scale.sv
module tb_peak_decim_scale;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [18:0] in_data;
  logic        peak_en;
  logic        dec_phase;
  logic [1:0]  div_sel;
  logic        out_valid;
  logic [9:0]  out_peak;
  logic        out_ovf;

  always #2 clk = ~clk;

  peak_decim_scale dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .peak_en(peak_en), .dec_phase(dec_phase), .div_sel(div_sel),
    .out_valid(out_valid), .out_peak(out_peak), .out_ovf(out_ovf)
  );

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R10";

  // reference model state
  logic [15:0] ma, mb;
  int          mfill, mk;
  logic [9:0]  mlast;
  logic        movf;
  logic        rv [4];
  logic [9:0]  rp [4];
  logic        ro [4];

  // stimulus table: bit 19 = valid, bits 18:0 = sample
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 19'h00087}, {1'b1, 19'h00105}, {1'b1, 19'h00307}, {1'b0, 19'h7FFFF},
    {1'b1, 19'h00200}, {1'b1, 19'h00100}, {1'b1, 19'h00800}, {1'b1, 19'h00800},
    {1'b1, 19'h00400}, {1'b1, 19'h02000}, {1'b1, 19'h00000}, {1'b1, 19'h04000},
    {1'b1, 19'h04003}, {1'b1, 19'h01000}, {1'b0, 19'h00000}, {1'b1, 19'h00008}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    ma = '0; mb = '0; mfill = 0; mk = 0; mlast = '0; movf = 1'b0;
    for (int i = 0; i < 4; i++) begin rv[i] = 0; rp[i] = '0; ro[i] = 0; end
  endtask

  task automatic step(input logic v, input logic [18:0] d);
    logic [15:0] x, res, sh;
    logic        keep;
    chk("out_valid", int'(out_valid), int'(rv[cyc % 4]));
    chk("out_peak",  int'(out_peak),  int'(rp[cyc % 4]));
    chk("out_ovf",   int'(out_ovf),   int'(ro[cyc % 4]));
    in_valid = v;
    in_data  = d;
    keep = 1'b0;
    if (v) begin
      x = d[18:3];
      if (mfill == 2) begin
        if (peak_en) res = ((ma > mb) && (ma >= x)) ? ma : 16'h0;
        else         res = ma;
        keep = ((mk % 2) == int'(dec_phase));
        mk++;
        if (keep) begin
          sh    = res >> div_sel;
          mlast = sh[9:0];
          movf  = |sh[15:10];
        end
      end
      mb = ma;
      ma = x;
      if (mfill < 2) mfill++;
    end
    rv[(cyc + 3) % 4] = keep;
    rp[(cyc + 3) % 4] = mlast;
    ro[(cyc + 3) % 4] = movf;
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic en, input logic ph, input logic [1:0] dv);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    peak_en = en; dec_phase = ph; div_sel = dv;
    @(negedge clk);
    @(negedge clk);
    // R10: reset state
    chk("reset out_valid", int'(out_valid), 0);
    chk("reset out_peak",  int'(out_peak),  0);
    chk("reset out_ovf",   int'(out_ovf),   0);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 19'h0);
  endtask

  task automatic run_table();
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19], VEC[i][18:0]);
      step(1'b0, 19'h0);
    end
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    peak_en = 1'b1; dec_phase = 1'b0; div_sel = 2'd0;
    model_clear();
    @(negedge clk);

    // R10 reset state
    cur_req = "R10";
    do_reset(1'b1, 1'b0, 2'd0);

    // R1 R2 R3 table, detection on, phase 0
    cur_req = "R1 R2 R3";
    run_table();

    // R6 R7 other phase, same timing
    cur_req = "R6 R7";
    do_reset(1'b1, 1'b1, 2'd0);
    run_table();

    // R4 R8 pass-through with divide by two
    cur_req = "R4 R8";
    do_reset(1'b0, 1'b0, 2'd1);
    run_table();
    do_reset(1'b0, 1'b1, 2'd2);
    run_table();

    // R8 R9 overflow boundary at each shift
    cur_req = "R8 R9";
    for (int dv = 0; dv < 4; dv++) begin
      do_reset(1'b0, 1'b0, dv[1:0]);
      step(1'b1, 19'h7FFF8);
      step(1'b1, 19'h01FF8);
      step(1'b1, 19'h02000);
      step(1'b1, 19'h03FF8);
      step(1'b1, 19'h1FFF8);
      step(1'b1, 19'h00008);
      step(1'b1, 19'h7FFFF);
      step(1'b1, 19'h00000);
      drain();
    end

    // R6 R7 R10 back-to-back samples, detection on
    cur_req = "R6 R7 R10";
    do_reset(1'b1, 1'b0, 2'd0);
    for (int i = 0; i < 12; i++) step(1'b1, 19'((i < 6 ? i : 11 - i) * 8 * 37));
    for (int i = 0; i < 8; i++) step(1'b1, 19'(((i % 3) + 1) * 64));
    drain();

    // R3 flat tops back-to-back
    cur_req = "R3";
    do_reset(1'b1, 1'b1, 2'd0);
    step(1'b1, 19'h00080); step(1'b1, 19'h00400); step(1'b1, 19'h00400);
    step(1'b1, 19'h00100); step(1'b1, 19'h00400); step(1'b1, 19'h00400);
    step(1'b1, 19'h00080);
    drain();

    // R5 reset in the middle of a stream discards history
    cur_req = "R5";
    do_reset(1'b1, 1'b0, 2'd0);
    step(1'b1, 19'h00100); step(1'b1, 19'h04000); step(1'b1, 19'h00080);
    do_reset(1'b1, 1'b0, 2'd0);
    step(1'b1, 19'h00008); step(1'b1, 19'h00000);
    step(1'b0, 19'h0); step(1'b0, 19'h0);
    step(1'b1, 19'h00000); step(1'b1, 19'h00000);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule